// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recently used page-table entries and translates a 32-bit virtual address into a 32-bit physical address. Pages are 4 KB. The upper 20 bits of the virtual address are the virtual page number. That number is compared against every stored entry in the same cycle. The lower 12 bits are the page offset and pass straight through. Because only the page number takes part in the compare, a neighbouring cache can index with the offset bits while the lookup runs.

A lookup that hits returns the physical address, the entry's permission bits and the entry's reference and dirty bits. A lookup that misses raises a miss flag. An outside agent then walks the page table and installs the translation through the fill port. The block keeps the reference and dirty bits up to date and uses the reference bits to choose which entry a fill replaces. A write that hits a page without write permission is reported as a protection fault. This report is separate from a miss. A flush input drops every translation at once.

Top module: `tlb_fa`

## Requirements
- R1: A lookup presented with `lk_valid` high on a clock edge produces its result on the outputs after that edge. `res_valid` is high for exactly that one cycle and low in a cycle that follows no lookup.
- R2: On a hit, `res_paddr` is the stored 20-bit frame number followed by `lk_vaddr[11:0]`, and `res_perm` is the entry's permission field. Bit 0 of that field allows reads and bit 1 allows writes.
- R3: When no valid entry matches `lk_vaddr[31:12]`, `res_miss` is 1 and `res_hit` is 0. On a hit the reverse holds. On a miss, `res_paddr`, `res_perm`, `res_ref` and `res_dirty` are 0.
- R4: `res_ref` reports the entry's reference bit as it stood before the lookup. Every hit sets that bit, so a second hit on the same entry reports 1.
- R5: A write hit on an entry whose permission bit 1 is set sets the dirty bit. `res_dirty` reports the dirty bit as it stood before the lookup.
- R6: A write hit on an entry whose permission bit 1 is clear raises `res_prot_fault` with `res_hit` still high, and leaves the dirty bit clear.
- R7: `res_prot_fault` is never raised by a read or by a miss.
- R8: If more than one valid entry matches, `res_multi_hit` is 1 and the result comes from the lowest-numbered matching entry.
- R9: A fill writes page number, frame number and permissions, with reference and dirty bits clear, into the lowest-numbered invalid entry if one exists.
- R10: When all entries are valid, a fill replaces the lowest-numbered entry whose reference bit is clear.
- R11: When all entries are valid and all reference bits are set, a fill clears every reference bit and replaces entry 0.
- R12: `flush` invalidates every entry in one cycle, so the next lookup misses.
- R13: After reset all entries are invalid and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_perm | input | 2 | Permissions to install (bit 0 read, bit 1 write) |
| res_valid | output | 1 | Result is valid this cycle |
| res_hit | output | 1 | Lookup hit |
| res_miss | output | 1 | Lookup missed |
| res_prot_fault | output | 1 | Write to a write-protected page |
| res_multi_hit | output | 1 | More than one entry matched |
| res_paddr | output | 32 | Translated physical address |
| res_perm | output | 2 | Permissions of the hit entry |
| res_ref | output | 1 | Reference bit before this access |
| res_dirty | output | 1 | Dirty bit before this access |

## Verification
Every lookup result is registered once, so it is due one clock after the edge that samples `lk_valid`. The bench drives inputs on the falling edge and reads results on the next falling edge. Fill and flush update entry state on the edge that samples them, so the bench's next lookup already sees the new contents. The bench observes reference and dirty updates one lookup later through `res_ref` and `res_dirty`. It observes replacement choices through which pages hit and which miss after a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = 20;
  localparam int PERM_W = 2;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [VPN_W-1:0] key,
  input  logic [VPN_W-1:0] tags [N],
  input  logic [N-1:0]     vld,
  output logic [N-1:0]     match,
  output logic [N-1:0]     first,
  output logic             any,
  output logic             multi
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld[i] && (tags[i] == key);
  end
  assign first = match & (~match + 1'b1);
  assign any   = |match;
  assign multi = |(match & (match - 1'b1));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16
) (
  input  logic [N-1:0] vld,
  input  logic [N-1:0] refb,
  output logic [N-1:0] pick,
  output logic         clr_refs
);
  logic [N-1:0] free_v, old_v;
  assign free_v = ~vld;
  assign old_v  = vld & ~refb;

  always_comb begin
    clr_refs = 1'b0;
    if (|free_v)      pick = free_v & (~free_v + 1'b1);
    else if (|old_v)  pick = old_v & (~old_v + 1'b1);
    else begin
      pick     = {{(N-1){1'b0}}, 1'b1};
      clr_refs = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_prot_fault,
  output logic              res_multi_hit,
  output logic [VA_W-1:0]   res_paddr,
  output logic [PERM_W-1:0] res_perm,
  output logic              res_ref,
  output logic              res_dirty
);
  logic [VPN_W-1:0]  tag_q  [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [PERM_W-1:0] perm_q [N];
  logic [N-1:0] vld_q, ref_q, dirty_q;
  logic [N-1:0] vld_n, ref_n, dirty_n;

  logic [N-1:0] match, hit_oh, pick;
  logic         hit_any, multi, clr_refs;

  logic [PFN_W-1:0]  sel_pfn;
  logic [PERM_W-1:0] sel_perm;
  logic              sel_ref, sel_dirty;

  tlb_match #(.N(N)) u_match (
    .key(lk_vaddr[VA_W-1:OFF_W]), .tags(tag_q), .vld(vld_q),
    .match(match), .first(hit_oh), .any(hit_any), .multi(multi)
  );

  tlb_victim #(.N(N)) u_victim (
    .vld(vld_q), .refb(ref_q), .pick(pick), .clr_refs(clr_refs)
  );

  // One-hot read mux for the lowest matching entry
  always_comb begin
    sel_pfn = '0; sel_perm = '0; sel_ref = 1'b0; sel_dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_oh[i]) begin
        sel_pfn   |= pfn_q[i];
        sel_perm  |= perm_q[i];
        sel_ref   |= ref_q[i];
        sel_dirty |= dirty_q[i];
      end
    end
  end

  logic wr_ok;
  assign wr_ok = sel_perm[PERM_WR];

  // Next-state for per-entry status bits; flush over fill over lookup
  always_comb begin
    vld_n = vld_q; ref_n = ref_q; dirty_n = dirty_q;
    if (lk_valid && hit_any) begin
      ref_n = ref_n | hit_oh;
      if (lk_write && wr_ok) dirty_n = dirty_n | hit_oh;
    end
    if (fill_valid) begin
      if (clr_refs) ref_n = '0;
      vld_n   = vld_n | pick;
      ref_n   = ref_n & ~pick;
      dirty_n = dirty_n & ~pick;
    end
    if (flush) vld_n = '0;
  end

  // Entry payload storage, written only by the fill port
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (fill_valid && pick[i]) begin
        tag_q[i]  <= fill_vpn;
        pfn_q[i]  <= fill_pfn;
        perm_q[i] <= fill_perm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0; ref_q <= '0; dirty_q <= '0;
      res_valid <= 1'b0; res_hit <= 1'b0; res_miss <= 1'b0;
      res_prot_fault <= 1'b0; res_multi_hit <= 1'b0;
      res_paddr <= '0; res_perm <= '0; res_ref <= 1'b0; res_dirty <= 1'b0;
    end else begin
      vld_q <= vld_n; ref_q <= ref_n; dirty_q <= dirty_n;
      res_valid      <= lk_valid;
      res_hit        <= lk_valid && hit_any;
      res_miss       <= lk_valid && !hit_any;
      res_prot_fault <= lk_valid && hit_any && lk_write && !wr_ok;
      res_multi_hit  <= lk_valid && multi;
      res_paddr      <= (lk_valid && hit_any) ? {sel_pfn, lk_vaddr[OFF_W-1:0]} : '0;
      res_perm       <= (lk_valid && hit_any) ? sel_perm  : '0;
      res_ref        <= (lk_valid && hit_any) && sel_ref;
      res_dirty      <= (lk_valid && hit_any) && sel_dirty;
    end
  end

  // Checks placed beside the logic they guard
  assert_result_follows_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  assert_hit_xor_miss_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({res_hit, res_miss}));
  assert_fault_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    res_prot_fault |-> (res_hit && $past(lk_write)));
  assert_multi_is_hit_R8: assert property (@(posedge clk) disable iff (rst)
    res_multi_hit |-> res_hit);
  assert_pick_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $onehot(pick));
  assert_refs_cleared_R11: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !lk_valid && (&vld_q) && (&ref_q)) |=> (ref_q == '0));
  assert_flush_empties_R12: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));
endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  logic clk = 1'b0;
  logic rst, flush, lk_valid, lk_write, fill_valid;
  logic [31:0] lk_vaddr;
  logic [19:0] fill_vpn, fill_pfn;
  logic [1:0]  fill_perm;
  logic res_valid, res_hit, res_miss, res_prot_fault, res_multi_hit, res_ref, res_dirty;
  logic [31:0] res_paddr;
  logic [1:0]  res_perm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_fa u_dut (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_prot_fault(res_prot_fault),
    .res_multi_hit(res_multi_hit), .res_paddr(res_paddr), .res_perm(res_perm),
    .res_ref(res_ref), .res_dirty(res_dirty)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] va;
    logic        hit;
    logic        fault;
    logic [31:0] pa;
    logic        rf;
    logic        dt;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 32'h12345678, 1'b1, 1'b0, 32'hABCDE678, 1'b0, 1'b0},  // R2 R4
    '{1'b0, 32'h12345000, 1'b1, 1'b0, 32'hABCDE000, 1'b1, 1'b0},  // R4
    '{1'b1, 32'h12345FFF, 1'b1, 1'b0, 32'hABCDEFFF, 1'b1, 1'b0},  // R5
    '{1'b0, 32'h12345001, 1'b1, 1'b0, 32'hABCDE001, 1'b1, 1'b1},  // R5
    '{1'b1, 32'h00001ABC, 1'b1, 1'b1, 32'h00777ABC, 1'b0, 1'b0},  // R6
    '{1'b0, 32'h00001ABC, 1'b1, 1'b0, 32'h00777ABC, 1'b1, 1'b0},  // R6 R7
    '{1'b0, 32'h54321000, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0},  // R3
    '{1'b1, 32'h54321000, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0},  // R3 R7
    '{1'b0, 32'hFFFFFABC, 1'b1, 1'b0, 32'h00001ABC, 1'b0, 1'b0}   // R2
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic wr, input logic [31:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_write = wr; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] perm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] va, input logic exp, input string req);
    lookup(1'b0, va);
    check(res_hit == exp && res_miss == !exp, req, {30'd0, res_hit, res_miss}, {30'd0, exp, !exp});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; lk_valid = 1'b0; lk_write = 1'b0; lk_vaddr = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_perm = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13: reset state
    check({res_valid, res_hit, res_miss, res_prot_fault, res_multi_hit} == 5'b0 && res_paddr == 0,
          "R13 outputs", {27'd0, res_valid, res_hit, res_miss, res_prot_fault, res_multi_hit}, 32'd0);
    expect_hit(32'h12345678, 1'b0, "R13 empty after reset");
    @(negedge clk);
    check(res_valid == 1'b0, "R1 no lookup no result", {31'd0, res_valid}, 32'd0);

    fill(20'h12345, 20'hABCDE, 2'b11);  // entry 0
    fill(20'h00001, 20'h00777, 2'b01);  // entry 1, read only
    fill(20'hFFFFF, 20'h00001, 2'b11);  // entry 2

    foreach (VECS[k]) begin
      lookup(VECS[k].wr, VECS[k].va);
      check(res_valid == 1'b1, $sformatf("R1 vec%0d valid", k), {31'd0, res_valid}, 32'd1);
      check(res_hit == VECS[k].hit && res_miss == !VECS[k].hit, $sformatf("R3 vec%0d hit", k),
            {31'd0, res_hit}, {31'd0, VECS[k].hit});
      check(res_paddr == VECS[k].pa, $sformatf("R2 vec%0d paddr", k), res_paddr, VECS[k].pa);
      check(res_prot_fault == VECS[k].fault, $sformatf("R6 R7 vec%0d fault", k),
            {31'd0, res_prot_fault}, {31'd0, VECS[k].fault});
      check(res_ref == VECS[k].rf, $sformatf("R4 vec%0d ref", k), {31'd0, res_ref}, {31'd0, VECS[k].rf});
      check(res_dirty == VECS[k].dt, $sformatf("R5 vec%0d dirty", k), {31'd0, res_dirty}, {31'd0, VECS[k].dt});
    end
    lookup(1'b0, 32'h00001000);
    check(res_perm == 2'b01, "R2 perm field", {30'd0, res_perm}, 32'd1);

    // R8 and R9: duplicate page goes to entry 3; lowest match wins
    fill(20'h12345, 20'h22222, 2'b11);
    lookup(1'b0, 32'h12345010);
    check(res_multi_hit == 1'b1, "R8 multi flag", {31'd0, res_multi_hit}, 32'd1);
    check(res_paddr == 32'hABCDE010, "R8 lowest entry", res_paddr, 32'hABCDE010);
    lookup(1'b0, 32'hFFFFF000);
    check(res_multi_hit == 1'b0, "R8 single match", {31'd0, res_multi_hit}, 32'd0);

    // R12: flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_hit(32'h12345000, 1'b0, "R12 flushed page");
    expect_hit(32'hFFFFF000, 1'b0, "R12 flushed page 2");

    // R9: refill all 16 entries in order (vpn i+1 -> entry i)
    for (int i = 0; i < 16; i++) fill(20'(i + 1), 20'(i + 32'h100), 2'b11);
    lookup(1'b0, 32'h00001000);
    check(res_paddr == 32'h00100000 && res_ref == 1'b0, "R9 first slot", res_paddr, 32'h00100000);
    lookup(1'b0, 32'h00002000);
    // R10: entries 0,1 referenced; vpn 3 in entry 2 is evicted
    fill(20'h00064, 20'h00ABC, 2'b11);
    expect_hit(32'h00003000, 1'b0, "R10 evicted entry 2");
    expect_hit(32'h00064000, 1'b1, "R10 new page");
    expect_hit(32'h00004000, 1'b1, "R10 untouched entry kept");
    // R11: reference all remaining entries, then fill
    for (int v = 5; v <= 16; v++) lookup(1'b0, {20'(v), 12'h000});
    fill(20'h000C8, 20'h00DEF, 2'b11);
    expect_hit(32'h00001000, 1'b0, "R11 entry 0 replaced");
    lookup(1'b0, 32'h000C8123);
    check(res_hit && res_paddr == 32'h00DEF123, "R11 new page in entry 0", res_paddr, 32'h00DEF123);
    lookup(1'b0, 32'h00002000);
    check(res_hit && res_ref == 1'b0, "R11 refs cleared", {31'd0, res_ref}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule